// File: doc/BRIEF.md
# Write Guard and Status Byte for a Serial Nonvolatile Memory

This block keeps the status byte of a small serial nonvolatile memory. It also decides whether each write request from the serial command decoder may go ahead. The decoder reports decoded events as one-cycle pulses:

- latch set and latch clear;
- a status write, carrying a data byte;
- an array program request, carrying a start address;
- program start, raised together with the chip-select rising edge that closes a valid sequence;
- program done, raised when the self-timed cycle ends.

The guard answers every status write and program request with a grant or a deny pulse. A granted request is held as pending until the closing chip-select edge. At that edge it becomes the busy cycle. A pending request is dropped if chip select rises without a start pulse.

Permission depends on three things. The first is a software enable latch. The second is a block-lock level that protects zero, one, two or four quarters of the array, always counted from the top. The third is a hardware protect pin, which acts only when a stored enable bit is set. The stored protection bits are plain flops that reset to a parameter value.

Top module: `wprot_status`

## Requirements
- R1: After reset the status byte reads the parameter `NV_INIT` in its stored bits, with the enable latch and the busy bit both at 0. With the default parameter value the byte reads 0x00.
- R2: The status byte layout is fixed when idle:
  - bit 7 is the protect-enable bit;
  - bits 6..4 read 0;
  - bits 3:2 are the lock level;
  - bit 1 is the enable latch;
  - bit 0 is busy.
- R3: A latch-set pulse sets status bit 1 and a latch-clear pulse clears it. Either change is visible one cycle after the pulse.
- R4: A status write or program request made while the enable latch is 0 is denied.
- R5: A completed status-write cycle stores data bits 7, 3 and 2 only. The written values of bits 6..4 and 1..0 have no effect on the status byte.
- R6: Hardware protection is active when `pp_n` is 0 and the protect-enable bit is 1. While it is active every status write is denied. With `pp_n` at 1, or with protect-enable at 0, a status write with the latch set is granted.
- R7: If hardware protection becomes active while a granted status write is pending and `cs_n` is still low, the write is cancelled and no busy cycle starts. Once the busy cycle has started, `pp_n` has no effect on it.
- R8: A program request is denied when the quarter it targets is locked. The quarter is the top two in-array address bits, `prog_addr[ADDR_W-1:ADDR_W-2]`. The lock levels are:
  - level 0 locks nothing;
  - level 1 locks quarter 3;
  - level 2 locks quarters 2 and 3;
  - level 3 locks all quarters.
- R9: Program requests to unlocked quarters are granted even while hardware protection is active.
- R10: While busy, the status byte reads 0xFF. Every command except done is ignored: no grant, no deny, no latch change.
- R11: The enable latch clears when a busy cycle completes. A denied request leaves it set.
- R12: Each status write or program request made while idle with nothing pending gets exactly one of grant or deny, as a one-cycle pulse in the cycle after the request.
- R13: A pending request is dropped when `cs_n` rises without a start pulse, and a later start pulse then begins no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select from the serial interface, low while selected |
| pp_n | input | 1 | Hardware protect pin, active low |
| cmd_latch_set | input | 1 | Pulse: set the enable latch |
| cmd_latch_clr | input | 1 | Pulse: clear the enable latch |
| cmd_stat_wr | input | 1 | Pulse: status write request |
| stat_wdata | input | 8 | Data byte for the status write |
| cmd_prog_req | input | 1 | Pulse: array program request |
| prog_addr | input | ADDR_W | Start address of the program request |
| cmd_prog_start | input | 1 | Pulse: sequence closed validly, start the cycle |
| cmd_prog_done | input | 1 | Pulse: self-timed cycle finished |
| status_byte | output | 8 | Status byte for reads |
| stat_grant | output | 1 | Status write granted |
| stat_deny | output | 1 | Status write denied |
| prog_grant | output | 1 | Program request granted |
| prog_deny | output | 1 | Program request denied |

## Verification
The bench targets the cancel window: protect drops while chip select is still low. A design that checks protection only when the write is requested would then commit the write. The bench also drops protect during the busy cycle, where a design that rechecks it would lose the commit. Random addresses are swept against every lock level. An off-by-one quarter decode, or reversed lock levels, would grant programs into locked quarters or refuse free ones. Denials are followed by reads of the latch, which catches a design that clears it on refusal. Status writes use random bytes, which exposes any design that lets bits 6..4 or 1..0 leak into the stored byte.

// File: rtl/wps_pkg.sv
package wps_pkg;

  typedef struct packed {
    logic       ppen;
    logic [1:0] lvl;
  } nv_t;

  // Lock decision for one quarter of the array, counted from the top.
  function automatic logic seg_locked(input logic [1:0] lvl, input logic [1:0] seg);
    logic hit;
    case (lvl)
      2'd0:    hit = 1'b0;
      2'd1:    hit = (seg == 2'd3);
      2'd2:    hit = seg[1];
      default: hit = 1'b1;
    endcase
    return hit;
  endfunction

  // Byte presented to a status read.
  function automatic logic [7:0] status_pack(input nv_t nv, input logic wel, input logic busy);
    logic [7:0] b;
    if (busy) b = 8'hFF;
    else      b = {nv.ppen, 3'b000, nv.lvl, wel, 1'b0};
    return b;
  endfunction

  // Extract the stored fields from a written byte.
  function automatic nv_t nv_from_byte(input logic [7:0] d);
    nv_t n;
    n.ppen = d[7];
    n.lvl  = d[3:2];
    return n;
  endfunction

endpackage

// File: rtl/wps_nvbits.sv
module wps_nvbits
  import wps_pkg::*;
#(
  parameter logic [2:0] NV_INIT = 3'b000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  nv_t  commit_val,
  output nv_t  nv_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      nv_q <= nv_t'(NV_INIT);
    else if (commit) nv_q <= commit_val;
  end

  // R5: stored bits change only on a committed status cycle
  p_nv_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(nv_q));

endmodule

// File: rtl/wps_guard.sv
module wps_guard
  import wps_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  nv_t               nv,
  input  logic              pp_n,
  input  logic              wel,
  input  logic              busy,
  input  logic              pend_any,
  input  logic [ADDR_W-1:0] addr,
  output logic              hw_prot,
  output logic              lock_hit,
  output logic              stat_ok,
  output logic              prog_ok
);

  localparam int SEG_HI = ADDR_W - 1;
  localparam int SEG_LO = ADDR_W - 2;

  logic       idle_free;
  logic [1:0] seg;

  assign seg       = addr[SEG_HI:SEG_LO];
  assign hw_prot   = ~pp_n & nv.ppen;
  assign lock_hit  = seg_locked(nv.lvl, seg);
  assign idle_free = wel & ~busy & ~pend_any;
  assign stat_ok   = idle_free & ~hw_prot;
  assign prog_ok   = idle_free & ~lock_hit;

  logic unused_addr_low;
  assign unused_addr_low = ^addr[SEG_LO-1:0];

endmodule

// File: rtl/wps_cycle.sv
module wps_cycle
  import wps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       cmd_latch_set,
  input  logic       cmd_latch_clr,
  input  logic       cmd_stat_wr,
  input  logic [7:0] stat_wdata,
  input  logic       cmd_prog_req,
  input  logic       cmd_prog_start,
  input  logic       cmd_prog_done,
  input  logic       hw_prot,
  input  logic       stat_ok,
  input  logic       prog_ok,
  output logic       wel_q,
  output logic       busy_q,
  output logic       pend_any,
  output logic       stat_grant_q,
  output logic       stat_deny_q,
  output logic       prog_grant_q,
  output logic       prog_deny_q,
  output logic       commit,
  output nv_t        commit_val,
  output logic       cancel_evt,
  output logic       start_evt
);

  logic pend_stat_q, pend_prog_q, busy_stat_q;
  nv_t  pend_val_q;

  assign pend_any   = pend_stat_q | pend_prog_q;
  assign cancel_evt = ~busy_q & pend_stat_q & hw_prot & ~cs_n;
  assign start_evt  = ~busy_q & cmd_prog_start & (pend_prog_q | (pend_stat_q & ~hw_prot));
  assign commit     = busy_q & cmd_prog_done & busy_stat_q;
  assign commit_val = pend_val_q;

  logic unused_wbits;
  assign unused_wbits = ^{stat_wdata[6:4], stat_wdata[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q        <= 1'b0;
      busy_q       <= 1'b0;
      busy_stat_q  <= 1'b0;
      pend_stat_q  <= 1'b0;
      pend_prog_q  <= 1'b0;
      pend_val_q   <= '0;
      stat_grant_q <= 1'b0;
      stat_deny_q  <= 1'b0;
      prog_grant_q <= 1'b0;
      prog_deny_q  <= 1'b0;
    end else begin
      stat_grant_q <= 1'b0;
      stat_deny_q  <= 1'b0;
      prog_grant_q <= 1'b0;
      prog_deny_q  <= 1'b0;
      if (busy_q) begin
        if (cmd_prog_done) begin
          busy_q      <= 1'b0;
          busy_stat_q <= 1'b0;
          wel_q       <= 1'b0;
        end
      end else begin
        if (cmd_latch_set)      wel_q <= 1'b1;
        else if (cmd_latch_clr) wel_q <= 1'b0;
        if (cmd_stat_wr && !pend_any) begin
          if (stat_ok) begin
            pend_stat_q  <= 1'b1;
            pend_val_q   <= nv_from_byte(stat_wdata);
            stat_grant_q <= 1'b1;
          end else begin
            stat_deny_q  <= 1'b1;
          end
        end
        if (cmd_prog_req && !pend_any) begin
          if (prog_ok) begin
            pend_prog_q  <= 1'b1;
            prog_grant_q <= 1'b1;
          end else begin
            prog_deny_q  <= 1'b1;
          end
        end
        if (cancel_evt) pend_stat_q <= 1'b0;
        if (start_evt) begin
          busy_q      <= 1'b1;
          busy_stat_q <= pend_stat_q;
          pend_stat_q <= 1'b0;
          pend_prog_q <= 1'b0;
        end else if (cs_n) begin
          pend_stat_q <= 1'b0;
          pend_prog_q <= 1'b0;
        end
      end
    end
  end

  // R4: no grant unless the latch was set when the request arrived
  p_grant_needs_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_grant_q || prog_grant_q) |-> $past(wel_q));

  // R6: no status grant while hardware protection was active
  p_stat_blocked_hw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_grant_q |-> !$past(hw_prot));

  // R10: busy holds and the latch does not move until done
  p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !cmd_prog_done) |=> (busy_q && $stable(wel_q)));

  // R11: latch is clear after a cycle completes
  p_latch_clr_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !wel_q);

  // R12: grant and deny are never raised together
  p_resp_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_grant_q && stat_deny_q) && !(prog_grant_q && prog_deny_q));

  // R7: a cancel leaves no busy cycle behind it
  p_cancel_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel_evt && !pend_prog_q) |=> !busy_q);

endmodule

// File: rtl/wprot_status.sv
module wprot_status
  import wps_pkg::*;
#(
  parameter int         ARRAY_BYTES = 8192,
  parameter int         ADDR_W      = $clog2(ARRAY_BYTES),
  parameter logic [2:0] NV_INIT     = 3'b000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              pp_n,
  input  logic              cmd_latch_set,
  input  logic              cmd_latch_clr,
  input  logic              cmd_stat_wr,
  input  logic [7:0]        stat_wdata,
  input  logic              cmd_prog_req,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic              cmd_prog_start,
  input  logic              cmd_prog_done,
  output logic [7:0]        status_byte,
  output logic              stat_grant,
  output logic              stat_deny,
  output logic              prog_grant,
  output logic              prog_deny
);

  nv_t  nv_q, commit_val;
  logic wel_q, busy_q, pend_any;
  logic hw_prot, lock_hit, stat_ok, prog_ok;
  logic commit, cancel_evt, start_evt;

  wps_nvbits #(.NV_INIT(NV_INIT)) u_nv (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_val(commit_val), .nv_q(nv_q)
  );

  wps_guard #(.ADDR_W(ADDR_W)) u_guard (
    .nv(nv_q), .pp_n(pp_n), .wel(wel_q), .busy(busy_q), .pend_any(pend_any),
    .addr(prog_addr), .hw_prot(hw_prot), .lock_hit(lock_hit),
    .stat_ok(stat_ok), .prog_ok(prog_ok)
  );

  wps_cycle u_cycle (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
    .cmd_latch_set(cmd_latch_set), .cmd_latch_clr(cmd_latch_clr),
    .cmd_stat_wr(cmd_stat_wr), .stat_wdata(stat_wdata),
    .cmd_prog_req(cmd_prog_req), .cmd_prog_start(cmd_prog_start),
    .cmd_prog_done(cmd_prog_done), .hw_prot(hw_prot),
    .stat_ok(stat_ok), .prog_ok(prog_ok),
    .wel_q(wel_q), .busy_q(busy_q), .pend_any(pend_any),
    .stat_grant_q(stat_grant), .stat_deny_q(stat_deny),
    .prog_grant_q(prog_grant), .prog_deny_q(prog_deny),
    .commit(commit), .commit_val(commit_val),
    .cancel_evt(cancel_evt), .start_evt(start_evt)
  );

  assign status_byte = status_pack(nv_q, wel_q, busy_q);

  // R8: no program grant for a request that targeted a locked quarter
  p_locked_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_grant |-> !$past(lock_hit));

  // R10: the byte read while busy is all ones
  p_busy_reads_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (status_byte == 8'hFF));

  // R13: a start pulse only opens a cycle when something was pending
  p_start_needs_pend_r13: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> pend_any);

endmodule

// File: tb/wprot_status_tb.sv
module wprot_status_tb;

  localparam int AW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0, pp_n = 1'b1;
  logic cmd_latch_set = 0, cmd_latch_clr = 0, cmd_stat_wr = 0, cmd_prog_req = 0;
  logic cmd_prog_start = 0, cmd_prog_done = 0;
  logic [7:0] stat_wdata = '0;
  logic [AW-1:0] prog_addr = '0;
  logic [7:0] status_byte;
  logic stat_grant, stat_deny, prog_grant, prog_deny;

  int checks = 0;
  int errors = 0;

  logic       e_ppen = 0;
  logic [1:0] e_lvl = 0;
  logic       e_wel = 0;

  always #2 clk = ~clk;

  wprot_status u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .pp_n(pp_n),
    .cmd_latch_set(cmd_latch_set), .cmd_latch_clr(cmd_latch_clr),
    .cmd_stat_wr(cmd_stat_wr), .stat_wdata(stat_wdata),
    .cmd_prog_req(cmd_prog_req), .prog_addr(prog_addr),
    .cmd_prog_start(cmd_prog_start), .cmd_prog_done(cmd_prog_done),
    .status_byte(status_byte), .stat_grant(stat_grant), .stat_deny(stat_deny),
    .prog_grant(prog_grant), .prog_deny(prog_deny)
  );

  function automatic logic [7:0] exp_status();
    return {e_ppen, 3'b000, e_lvl, e_wel, 1'b0};
  endfunction

  // Quarter q is locked when it lies among the top n quarters.
  function automatic logic exp_locked(input logic [1:0] lvl, input logic [AW-1:0] a);
    int n, q;
    n = (lvl == 2'd3) ? 4 : int'(lvl);
    q = int'(a) / (2 ** (AW - 2));
    return q >= (4 - n);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_set();
    @(negedge clk); cmd_latch_set = 1; @(negedge clk); cmd_latch_set = 0;
  endtask
  task automatic pulse_clr();
    @(negedge clk); cmd_latch_clr = 1; @(negedge clk); cmd_latch_clr = 0;
  endtask
  task automatic req_stat(input logic [7:0] d, output logic g, output logic dn);
    @(negedge clk); stat_wdata = d; cmd_stat_wr = 1;
    @(negedge clk); cmd_stat_wr = 0; g = stat_grant; dn = stat_deny;
  endtask
  task automatic req_prog(input logic [AW-1:0] a, output logic g, output logic dn);
    @(negedge clk); prog_addr = a; cmd_prog_req = 1;
    @(negedge clk); cmd_prog_req = 0; g = prog_grant; dn = prog_deny;
  endtask
  task automatic close_start();
    @(negedge clk); cs_n = 1; cmd_prog_start = 1;
    @(negedge clk); cmd_prog_start = 0; cs_n = 0;
  endtask
  task automatic close_drop();
    @(negedge clk); cs_n = 1; @(negedge clk); cs_n = 0;
  endtask
  task automatic done();
    @(negedge clk); cmd_prog_done = 1; @(negedge clk); cmd_prog_done = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic g, dn;
    logic [7:0] w;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset status", status_byte, 8'h00);

    req_prog('0, g, dn);
    check("R4 prog deny no latch", {g, dn}, 2'b01);
    req_stat(8'h8C, g, dn);
    check("R4 stat deny no latch", {g, dn}, 2'b01);

    pulse_set(); e_wel = 1;
    check("R3 latch set", status_byte, exp_status());
    pulse_clr(); e_wel = 0;
    check("R3 latch clear", status_byte, exp_status());
    pulse_set(); e_wel = 1;

    req_stat(8'hFF, g, dn);
    check("R12 stat grant", {g, dn}, 2'b10);
    close_start();
    check("R10 busy reads ones", status_byte, 8'hFF);
    pulse_clr();
    req_prog('0, g, dn);
    check("R10 busy ignores request", {g, dn}, 2'b00);
    done(); e_wel = 0; e_ppen = 1; e_lvl = 2'd3;
    check("R5 R11 stored bits only", status_byte, 8'h8C);

    pulse_set(); e_wel = 1;
    pp_n = 0;
    req_stat(8'h00, g, dn);
    check("R6 stat deny under hw protect", {g, dn}, 2'b01);
    req_prog(13'h0000, g, dn);
    check("R8 level 3 locks quarter 0", {g, dn}, 2'b01);
    check("R11 denial keeps latch", status_byte, 8'h8E);

    pp_n = 1;
    req_stat(8'h84, g, dn);
    check("R7 grant before cancel", {g, dn}, 2'b10);
    @(negedge clk); pp_n = 0;
    @(negedge clk); pp_n = 1;
    close_start();
    check("R7 cancelled write starts nothing", status_byte, 8'h8E);

    req_stat(8'h04, g, dn);
    check("R6 stat grant pp_n high", {g, dn}, 2'b10);
    close_start();
    @(negedge clk); pp_n = 0;
    done(); e_wel = 0; e_ppen = 0; e_lvl = 2'd1;
    check("R7 pp_n after start no effect", status_byte, 8'h04);

    pulse_set(); e_wel = 1;
    req_stat(8'h88, g, dn);
    check("R6 ppen 0 disables pin", {g, dn}, 2'b10);
    close_start(); done(); e_wel = 0; e_ppen = 1; e_lvl = 2'd2;
    check("R2 layout", status_byte, exp_status());

    pulse_set(); e_wel = 1;
    req_prog(13'h1800, g, dn);
    check("R8 level 2 locks quarter 3", {g, dn}, 2'b01);
    req_stat(8'h00, g, dn);
    check("R6 deny again", {g, dn}, 2'b01);
    req_prog(13'h0000, g, dn);
    check("R9 unlocked under hw protect", {g, dn}, 2'b10);
    close_start(); done(); e_wel = 0;
    check("R11 latch clear after program", status_byte, exp_status());

    pp_n = 1;
    pulse_set(); e_wel = 1;
    req_stat(8'h00, g, dn);
    close_drop();
    close_start();
    check("R13 dropped request", status_byte, exp_status());

    for (int i = 0; i < 40; i++) begin
      logic use_l;
      logic [AW-1:0] a;
      logic eg;
      w = 8'($urandom);
      if (!e_wel) begin pulse_set(); e_wel = 1; end
      req_stat(w, g, dn);
      check("R12 random stat grant", {g, dn}, 2'b10);
      close_start(); done();
      e_wel = 0; e_ppen = w[7]; e_lvl = w[3:2];
      check("R5 random write", status_byte, exp_status());
      use_l = ($urandom % 4) != 0;
      if (use_l) begin pulse_set(); e_wel = 1; end
      a = AW'($urandom);
      req_prog(a, g, dn);
      eg = use_l && !exp_locked(e_lvl, a);
      check("R8 random lock decode", {g, dn}, {eg, ~eg});
      if (g) begin
        close_start(); done(); e_wel = 0;
      end else begin
        close_drop();
      end
      check("R11 random latch", status_byte, exp_status());
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule